// File: doc/BRIEF.md
# Complete-Split Progress Tracker

This block follows the complete-split phase of a single periodic interrupt split transaction on a high-speed host. At the start of each microframe it turns the low three bits of the frame index into a one-hot marker for the current microframe. It also keeps the frame number, which is the rest of the index. When the host runs a complete-split, the block sets the marker's bit in a progress vector. Before doing so, it checks that every complete-split scheduled earlier in the same frame, as given by the C-mask, has already been recorded.

A skipped complete-split or an unrecoverable complete-split error counts as lost data. For an IN transfer the block halts the queue. For an OUT transfer it raises a sticky progress error and leaves the endpoint running. The byte field adds up the payload received on clean IN complete-splits, or holds the byte count sent in the start-split for OUT. A frame tag holds the frame in which the next scheduled complete-split must run. A new start-split clears the progress state.

Top module: `csplit_tracker`

## Requirements
- R1: One cycle after `uframe_start`, `cur_uf_bit` equals 1 shifted left by `frame_idx[2:0]`. It holds its value otherwise and never has more than one bit set.
- R2: A complete-split that is taken sets, one cycle later, the bit of `prog_mask` at the current microframe's position. Bit n stands for microframe n.
- R3: When a complete-split is taken, a skip is detected if any bit of `cmask` below the current microframe's bit is clear in `prog_mask`.
- R4: Data loss on an IN transfer (`is_in`=1) sets `halt` one cycle later. `halt` stays set until the next start-split.
- R5: Data loss on an OUT transfer (`is_in`=0) sets a sticky `xfer_err` and leaves `halt` clear.
- R6: A complete-split with `csplit_err`=1 is treated as data loss, even when no skip is present.
- R7: On a clean IN complete-split, `rx_bytes` is added to `byte_cnt`, modulo 2^BYTE_W. OUT complete-splits and lossy complete-splits leave `byte_cnt` unchanged.
- R8: `ssplit_go` clears `prog_mask`, `halt` and `xfer_err`. It loads `byte_cnt` with `out_bytes` for OUT, or with 0 for IN, and takes priority over `csplit_go`.
- R9: After a taken complete-split, `frame_tag` is the current frame if `cmask` has a bit above the current microframe. Otherwise it is the current frame plus 1, modulo 2^(IDX_W-3).
- R10: While `halt` is set, `csplit_go` changes nothing: `prog_mask`, `byte_cnt`, `frame_tag` and `data_loss` keep their values.
- R11: After reset all outputs are 0. `data_loss` pulses for one cycle, one cycle after each lossy complete-split.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uframe_start | input | 1 | Start-of-microframe strobe |
| frame_idx | input | IDX_W | Frame index counter |
| cmask | input | 8 | Microframes scheduled for complete-splits |
| ssplit_go | input | 1 | Start-split issued |
| is_in | input | 1 | 1 = interrupt-IN, 0 = interrupt-OUT |
| out_bytes | input | BYTE_W | Bytes sent in the start-split (OUT) |
| csplit_go | input | 1 | Complete-split runs this cycle |
| csplit_err | input | 1 | Unrecoverable error on this complete-split |
| rx_bytes | input | BYTE_W | Bytes received in this complete-split |
| cur_uf_bit | output | 8 | One-hot current microframe |
| prog_mask | output | 8 | Complete-splits done in this transaction |
| byte_cnt | output | BYTE_W | Byte field |
| frame_tag | output | IDX_W-3 | Frame of the next complete-split |
| halt | output | 1 | Queue halted (IN loss) |
| xfer_err | output | 1 | Progress error (OUT loss) |
| data_loss | output | 1 | One-cycle data-loss pulse |

## Verification
The bench builds the block with IDX_W=5 and BYTE_W=6. With these values the frame number is only two bits wide, so the frame tag wraps from frame 3 to frame 0 within a few microframes. The byte field also overflows after a handful of IN complete-splits. Both wrap cases are therefore reached in a short run, next to skip detection at the first and last microframes of a frame.

// File: rtl/csplit_pkg.sv
package csplit_pkg;
  localparam int UF_N = 8;
  typedef logic [UF_N-1:0] uf_vec_t;

  // one-hot marker for a microframe number
  function automatic uf_vec_t uf_onehot(input logic [2:0] sel);
    return uf_vec_t'(1) << sel;
  endfunction

  // microframes strictly before the marked one (marker must be nonzero)
  function automatic uf_vec_t below_mask(input uf_vec_t cur);
    return cur - uf_vec_t'(1);
  endfunction

  // microframes strictly after the marked one
  function automatic uf_vec_t above_mask(input uf_vec_t cur);
    return ~(cur | (cur - uf_vec_t'(1)));
  endfunction
endpackage

// File: rtl/uf_marker.sv
module uf_marker
  import csplit_pkg::*;
#(
  parameter int IDX_W = 14,
  localparam int FR_W = IDX_W - 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             uframe_start,
  input  logic [IDX_W-1:0] frame_idx,
  output uf_vec_t          cur_bit,
  output logic [FR_W-1:0]  cur_frame
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_bit   <= '0;
      cur_frame <= '0;
    end else if (uframe_start) begin
      cur_bit   <= uf_onehot(frame_idx[2:0]);
      cur_frame <= frame_idx[IDX_W-1:3];
    end
  end

  assert_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cur_bit));
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !uframe_start |=> $stable(cur_bit) && $stable(cur_frame));
endmodule

// File: rtl/progress_check.sv
module progress_check
  import csplit_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    clear,
  input  logic    take,
  input  logic    err,
  input  logic    is_in,
  input  uf_vec_t cmask,
  input  uf_vec_t cur_bit,
  output uf_vec_t prog_mask,
  output logic    halt,
  output logic    xfer_err,
  output logic    data_loss,
  output logic    clean_evt
);
  uf_vec_t missing;
  logic    skip_evt;
  logic    loss_evt;

  assign missing   = cmask & below_mask(cur_bit) & ~prog_mask;
  assign skip_evt  = take && (missing != '0);
  assign loss_evt  = take && (skip_evt || err);
  assign clean_evt = take && !loss_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_mask <= '0;
      halt      <= 1'b0;
      xfer_err  <= 1'b0;
      data_loss <= 1'b0;
    end else if (clear) begin
      prog_mask <= '0;
      halt      <= 1'b0;
      xfer_err  <= 1'b0;
      data_loss <= 1'b0;
    end else begin
      data_loss <= loss_evt;
      if (take) prog_mask <= prog_mask | cur_bit;
      if (loss_evt && is_in)  halt     <= 1'b1;
      if (loss_evt && !is_in) xfer_err <= 1'b1;
    end
  end

  assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !clear) |=> ((prog_mask & $past(cur_bit)) == $past(cur_bit)));
  assert_in_halt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (loss_evt && is_in && !clear) |=> halt);
  assert_out_nohalt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (loss_evt && !is_in && !halt && !clear) |=> (!halt && xfer_err));
  assert_err_loss_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && err && !clear) |=> data_loss);
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (prog_mask == '0 && !halt && !xfer_err));
endmodule

// File: rtl/byte_accum.sv
module byte_accum #(
  parameter int BYTE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_val,
  input  logic              add_en,
  input  logic [BYTE_W-1:0] add_val,
  output logic [BYTE_W-1:0] total
);
  always_ff @(posedge clk) begin
    if (!rst_n)      total <= '0;
    else if (load)   total <= load_val;
    else if (add_en) total <= total + add_val;
  end

  assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !add_en) |=> $stable(total));
endmodule

// File: rtl/csplit_tracker.sv
module csplit_tracker
  import csplit_pkg::*;
#(
  parameter int IDX_W  = 14,
  parameter int BYTE_W = 11,
  localparam int FR_W  = IDX_W - 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uframe_start,
  input  logic [IDX_W-1:0]  frame_idx,
  input  logic [7:0]        cmask,
  input  logic              ssplit_go,
  input  logic              is_in,
  input  logic [BYTE_W-1:0] out_bytes,
  input  logic              csplit_go,
  input  logic              csplit_err,
  input  logic [BYTE_W-1:0] rx_bytes,
  output logic [7:0]        cur_uf_bit,
  output logic [7:0]        prog_mask,
  output logic [BYTE_W-1:0] byte_cnt,
  output logic [FR_W-1:0]   frame_tag,
  output logic              halt,
  output logic              xfer_err,
  output logic              data_loss
);
  logic [FR_W-1:0]   cur_frame;
  logic              take;
  logic              clean_evt;
  logic              later_due;
  logic [BYTE_W-1:0] start_val;

  assign take      = csplit_go && !halt && !ssplit_go;
  assign later_due = (cmask & above_mask(cur_uf_bit)) != '0;
  assign start_val = is_in ? '0 : out_bytes;

  uf_marker #(.IDX_W(IDX_W)) marker_i (
    .clk(clk), .rst_n(rst_n), .uframe_start(uframe_start),
    .frame_idx(frame_idx), .cur_bit(cur_uf_bit), .cur_frame(cur_frame)
  );

  progress_check check_i (
    .clk(clk), .rst_n(rst_n), .clear(ssplit_go), .take(take),
    .err(csplit_err), .is_in(is_in), .cmask(cmask), .cur_bit(cur_uf_bit),
    .prog_mask(prog_mask), .halt(halt), .xfer_err(xfer_err),
    .data_loss(data_loss), .clean_evt(clean_evt)
  );

  byte_accum #(.BYTE_W(BYTE_W)) accum_i (
    .clk(clk), .rst_n(rst_n), .load(ssplit_go), .load_val(start_val),
    .add_en(clean_evt && is_in), .add_val(rx_bytes), .total(byte_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)
      frame_tag <= '0;
    else if (take)
      frame_tag <= later_due ? cur_frame : cur_frame + {{(FR_W-1){1'b0}}, 1'b1};
  end

  assert_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !ssplit_go) |=> ($stable(prog_mask) && $stable(byte_cnt) && $stable(frame_tag)));
  assert_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (data_loss && !halt) |-> (halt || xfer_err));
endmodule

// File: tb/csplit_tracker_tb_top.sv
module csplit_tracker_tb_top;
  localparam int IDX_W = 5;
  localparam int BW    = 6;
  localparam int FW    = IDX_W - 3;

  typedef struct packed {
    logic [7:0]    cur;
    logic [7:0]    prog;
    logic [BW-1:0] bytes;
    logic [FW-1:0] tag;
    logic          halt;
    logic          xerr;
    logic          loss;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic uframe_start = 1'b0;
  logic [IDX_W-1:0] frame_idx = '0;
  logic [7:0] cmask = '0;
  logic ssplit_go = 1'b0;
  logic is_in = 1'b0;
  logic [BW-1:0] out_bytes = '0;
  logic csplit_go = 1'b0;
  logic csplit_err = 1'b0;
  logic [BW-1:0] rx_bytes = '0;
  logic [7:0] cur_uf_bit, prog_mask;
  logic [BW-1:0] byte_cnt;
  logic [FW-1:0] frame_tag;
  logic halt, xfer_err, data_loss;

  always #10 clk = ~clk;

  csplit_tracker #(.IDX_W(IDX_W), .BYTE_W(BW)) dut_i (
    .clk(clk), .rst_n(rst_n), .uframe_start(uframe_start), .frame_idx(frame_idx),
    .cmask(cmask), .ssplit_go(ssplit_go), .is_in(is_in), .out_bytes(out_bytes),
    .csplit_go(csplit_go), .csplit_err(csplit_err), .rx_bytes(rx_bytes),
    .cur_uf_bit(cur_uf_bit), .prog_mask(prog_mask), .byte_cnt(byte_cnt),
    .frame_tag(frame_tag), .halt(halt), .xfer_err(xfer_err), .data_loss(data_loss)
  );

  exp_t  exp_q[$];
  string name_q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  exp_t m;
  int   m_pos;
  int   m_frame;

  task automatic push(input string nm);
    exp_q.push_back(m);
    name_q.push_back(nm);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    uframe_start = 1'b0; ssplit_go = 1'b0; csplit_go = 1'b0; csplit_err = 1'b0;
  endtask

  task automatic do_uframe(input int idx, input string nm);
    @(negedge clk);
    uframe_start = 1'b1; frame_idx = IDX_W'(idx);
    step();
    m_pos = idx % 8;
    m_frame = idx / 8;
    m.cur = '0;
    for (int i = 0; i < 8; i++) if (i == m_pos) m.cur[i] = 1'b1;
    m.loss = 1'b0;
    push(nm);
  endtask

  task automatic do_ssplit(input bit dir_in, input int ob, input string nm);
    @(negedge clk);
    ssplit_go = 1'b1; is_in = dir_in; out_bytes = BW'(ob);
    step();
    m.prog = '0; m.halt = 0; m.xerr = 0; m.loss = 0;
    m.bytes = dir_in ? '0 : BW'(ob);
    push(nm);
  endtask

  task automatic do_csplit(input int rx, input bit err, input string nm);
    bit skip, later;
    @(negedge clk);
    csplit_go = 1'b1; csplit_err = err; rx_bytes = BW'(rx);
    step();
    if (m.halt) begin
      m.loss = 0;
    end else begin
      skip = 0; later = 0;
      for (int i = 0; i < m_pos; i++) if (cmask[i] && !m.prog[i]) skip = 1;
      for (int j = m_pos + 1; j < 8; j++) if (cmask[j]) later = 1;
      m.prog[m_pos] = 1'b1;
      m.loss = skip || err;
      if (m.loss) begin
        if (is_in) m.halt = 1; else m.xerr = 1;
      end else if (is_in) begin
        m.bytes = BW'((int'(m.bytes) + rx) % (1 << BW));
      end
      m.tag = later ? FW'(m_frame) : FW'((m_frame + 1) % (1 << FW));
    end
    push(nm);
  endtask

  // monitor: compares one expected item per falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      string nm;
      e  = exp_q.pop_front();
      nm = name_q.pop_front();
      checks++;
      if (cur_uf_bit !== e.cur || prog_mask !== e.prog || byte_cnt !== e.bytes ||
          frame_tag !== e.tag || halt !== e.halt || xfer_err !== e.xerr ||
          data_loss !== e.loss) begin
        fails++;
        $display("FAIL %s: got cur=%h prog=%h bytes=%0d tag=%0d halt=%b xerr=%b loss=%b, expected cur=%h prog=%h bytes=%0d tag=%0d halt=%b xerr=%b loss=%b",
          nm, cur_uf_bit, prog_mask, byte_cnt, frame_tag, halt, xfer_err, data_loss,
          e.cur, e.prog, e.bytes, e.tag, e.halt, e.xerr, e.loss);
      end
    end
  end

  initial begin
    m = '0; m_pos = 0; m_frame = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    push("R11 reset state");

    cmask = 8'b0001_1100;
    do_ssplit(1, 0, "R8 IN start clears");
    do_uframe(2, "R1 marker uf2");
    do_csplit(10, 0, "R2 R7 R9 first csplit uf2");
    do_uframe(3, "R1 marker uf3");
    do_csplit(20, 0, "R7 accumulate uf3");
    do_uframe(4, "R1 marker uf4");
    do_csplit(40, 0, "R7 byte wrap R9 tag next frame");
    do_ssplit(1, 0, "R8 restart IN");
    do_uframe(3, "R1 marker uf3 again");
    do_csplit(7, 0, "R3 R4 R11 skip halts IN");
    do_uframe(4, "R1 marker while halted");
    do_csplit(9, 0, "R10 csplit ignored when halted");
    do_ssplit(0, 17, "R8 OUT start loads bytes");
    do_uframe(2, "R1 marker uf2 OUT");
    do_csplit(5, 1, "R5 R6 error on OUT no halt");
    do_uframe(3, "R1 marker uf3 OUT");
    do_csplit(5, 0, "R7 OUT bytes unchanged, R5 sticky");
    do_uframe(31, "R1 marker frame3 uf7");
    do_csplit(5, 0, "R3 R9 skip at uf7, tag wraps");
    do_ssplit(1, 0, "R8 IN start clears error");
    cmask = 8'b0000_0001;
    do_uframe(0, "R1 marker uf0");
    do_csplit(3, 1, "R6 R4 error on IN halts");
    do_ssplit(1, 0, "R8 clear after halt");
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule